// File: doc/BRIEF.md
# Prioritized Interrupt Entry Sequencer

This block carries an 8-bit processor core from an instruction boundary into an interrupt service routine. Three requests compete: a non-maskable request that is captured on its rising edge and held pending, a fast maskable request and a normal maskable request. The maskable requests are level inputs, gated by two mask bits of the condition-code byte and looked at only when the core raises `boundary`. When a request wins, the block saves the register image to the stack one byte per cycle, then reads the two-byte service address in a separate phase, and finally hands back the new program counter, the new condition codes and the new stack pointer in a one-cycle `done` pulse.

A full entry saves the whole register image with the entire-state flag set. A fast entry saves only the program counter and the condition codes, with that flag cleared. When the core reports that a wait-for-interrupt instruction already saved the image (`stacked`), no stack writes happen and the block goes straight to the vector read. The memory side is a fixed-latency port: a write completes in the cycle it is issued, read data is returned in the same cycle as the address, and there is no back-pressure, so every entry takes a fixed number of cycles.

Condition-code bit positions used throughout: bit 7 is the entire-state flag E, bit 6 is the fast mask F, bit 4 is the normal mask I.

Top module: `irq_entry_seq`

## Requirements
- R1: At a boundary with more than one request eligible, the pending non-maskable request wins over the fast request, which wins over the normal request; a fast request with F set is passed over and the normal request is considered next.
- R2: The service address is read big-endian from 0xFFFC (non-maskable), 0xFFF6 (fast) or 0xFFF8 (normal): the high byte from the vector address in the first read cycle, the low byte from the next address in the second, and `pc_out` is the two bytes joined.
- R3: A non-maskable or normal entry without `stacked` writes twelve bytes in consecutive cycles starting with the first busy cycle, to addresses SP-1 down to SP-12, in the order PC low, PC high, U low, U high, Y low, Y high, X low, X high, DP, B, A, CC, where the CC byte written has E set.
- R4: A fast entry without `stacked` writes three bytes to SP-1, SP-2, SP-3: PC low, PC high, then CC with E cleared.
- R5: With `stacked` high at the boundary, no stack write is issued, the entry is busy for two cycles only, `sp_out` equals `sp_in`, and E in `cc_out` is taken unchanged from `cc_in`.
- R6: `cc_out` has I set after every entry and has F set after a non-maskable or fast entry; after a normal entry F keeps its input value.
- R7: Without `stacked`, `busy` is high for 19 consecutive cycles for a non-maskable or normal entry and 10 for a fast entry, and the last two of them are the vector read cycles.
- R8: `bus_status` is high exactly in the two vector read cycles, is low during stack writes, and is low again in the cycle `done` is high.
- R9: `done` and `wait_clr` pulse together for one cycle, in the cycle after the last vector read; taking the non-maskable request clears `nmi_pending`.
- R10: A non-maskable input held high triggers one entry only; a boundary with no eligible request (all masked or absent) starts no entry, and `boundary` has no effect while an entry is in progress.
- R11: After a stacking entry, `sp_out` is `sp_in` minus the number of bytes written (12 or 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Instruction boundary; requests are arbitrated in this cycle |
| nmi | input | 1 | Non-maskable request, rising-edge sensitive |
| firq | input | 1 | Fast maskable request, level |
| irq | input | 1 | Normal maskable request, level |
| cc_in | input | 8 | Current condition codes (E bit 7, F bit 6, I bit 4) |
| stacked | input | 1 | Register image already saved by wait-for-interrupt |
| sp_in | input | 16 | Current stack pointer |
| pc_in | input | 16 | Program counter to save |
| u_in | input | 16 | U register to save |
| y_in | input | 16 | Y register to save |
| x_in | input | 16 | X register to save |
| dp_in | input | 8 | Direct page register to save |
| b_in | input | 8 | B accumulator to save |
| a_in | input | 8 | A accumulator to save |
| busy | output | 1 | Entry in progress |
| mem_we | output | 1 | Stack byte write strobe |
| mem_re | output | 1 | Vector byte read strobe |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Stack write data |
| mem_rdata | input | 8 | Read data, valid in the cycle of the read |
| bus_status | output | 1 | High while the vector is fetched |
| done | output | 1 | One-cycle pulse: outputs below are valid |
| pc_out | output | 16 | Service routine address |
| cc_out | output | 8 | Updated condition codes |
| sp_out | output | 16 | Updated stack pointer |
| wait_clr | output | 1 | Pulse clearing the core's sync-wait and wait-for-interrupt flags |
| nmi_pending | output | 1 | Latched non-maskable request not yet taken |

## Verification
The assertions take for granted that `mem_rdata` is a pure function of the address within the read cycle and that the register, mask and stack inputs stay steady from the boundary until `done`; the stimulus holds every such input constant across each entry and drives `mem_rdata` from a combinational memory model. They also assume `boundary` is only one cycle wide, which the stimulus respects by raising it for a single cycle and only when the block is idle, apart from one directed case that raises it during an entry. Non-maskable edges are produced as one-cycle pulses at least a cycle before the boundary, so the pending latch is settled when arbitration samples it.

// File: rtl/ies_pkg.sv
package ies_pkg;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int VEC_CYC = 2;
  localparam int FULL_BYTES = 12;
  localparam int FAST_BYTES = 3;
  localparam int CC_E = 7;
  localparam int CC_F = 6;
  localparam int CC_I = 4;

  typedef enum logic [1:0] {SRC_NONE, SRC_NMI, SRC_FAST, SRC_NORM} src_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_VEC} state_e;

  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};

  function automatic logic [AW-1:0] vec_of(input src_e s);
    case (s)
      SRC_NMI:  vec_of = TOP_ADDR - AW'(3);
      SRC_FAST: vec_of = TOP_ADDR - AW'(9);
      default:  vec_of = TOP_ADDR - AW'(7);
    endcase
  endfunction
endpackage

// File: rtl/ies_arbiter.sv
module ies_arbiter
  import ies_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic nmi,
  input  logic firq,
  input  logic irq,
  input  logic mask_f,
  input  logic mask_i,
  input  logic sample,
  input  logic clear_nmi,
  output src_e pick,
  output logic nmi_pend
);
  logic nmi_q;
  logic nmi_rise;

  assign nmi_rise = nmi && !nmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q <= nmi;
      if (nmi_rise)       nmi_pend <= 1'b1;
      else if (clear_nmi) nmi_pend <= 1'b0;
    end
  end

  always_comb begin
    pick = SRC_NONE;
    if (sample) begin
      if (nmi_pend)             pick = SRC_NMI;
      else if (firq && !mask_f) pick = SRC_FAST;
      else if (irq && !mask_i)  pick = SRC_NORM;
    end
  end
endmodule

// File: rtl/ies_frame.sv
module ies_frame
  import ies_pkg::*;
#(
  parameter int SW = 5
)(
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] u,
  input  logic [AW-1:0] y,
  input  logic [AW-1:0] x,
  input  logic [DW-1:0] dp,
  input  logic [DW-1:0] b,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] ccp,
  input  logic          full,
  input  logic [SW-1:0] step,
  output logic [DW-1:0] byte_out
);
  localparam int IW = $clog2(FULL_BYTES);
  logic [FULL_BYTES*DW-1:0] img;
  logic [DW-1:0] bytes [FULL_BYTES];
  logic [IW-1:0] idx;

  assign img = {ccp, a, b, dp, x, y, u, pc};

  for (genvar g = 0; g < FULL_BYTES; g++) begin : g_split
    assign bytes[g] = img[g*DW +: DW];
  end

  always_comb begin
    if (!full && step == SW'(FAST_BYTES-1)) idx = IW'(FULL_BYTES-1);
    else if (step < SW'(FULL_BYTES))        idx = step[IW-1:0];
    else                                    idx = '0;
    byte_out = bytes[idx];
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import ies_pkg::*;
#(
  parameter int FULL_CYC = 19,
  parameter int FAST_CYC = 10
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          nmi,
  input  logic          firq,
  input  logic          irq,
  input  logic [7:0]    cc_in,
  input  logic          stacked,
  input  logic [15:0]   sp_in,
  input  logic [15:0]   pc_in,
  input  logic [15:0]   u_in,
  input  logic [15:0]   y_in,
  input  logic [15:0]   x_in,
  input  logic [7:0]    dp_in,
  input  logic [7:0]    b_in,
  input  logic [7:0]    a_in,
  output logic          busy,
  output logic          mem_we,
  output logic          mem_re,
  output logic [15:0]   mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic          bus_status,
  output logic          done,
  output logic [15:0]   pc_out,
  output logic [7:0]    cc_out,
  output logic [15:0]   sp_out,
  output logic          wait_clr,
  output logic          nmi_pending
);
  localparam int SW        = $clog2(FULL_CYC + 1);
  localparam int FULL_PUSH = FULL_CYC - VEC_CYC;
  localparam int FAST_PUSH = FAST_CYC - VEC_CYC;

  state_e          state;
  logic [SW-1:0]   step;
  src_e            src_r;
  src_e            pick;
  logic            stk_r;
  logic [AW-1:0]   pc_r, u_r, y_r, x_r, sp_r, vec_r;
  logic [DW-1:0]   dp_r, b_r, a_r, ccp_r, ccn_r, hi_r;
  logic            full_r;
  logic            sample, accept;
  logic [SW-1:0]   push_last, nbytes;
  logic [AW-1:0]   sp_dec;
  logic [DW-1:0]   frame_byte;
  logic [DW-1:0]   ccp_next, ccn_base, ccn_next;

  assign sample = boundary && (state == ST_IDLE);
  assign accept = sample && (pick != SRC_NONE);
  assign full_r = (src_r != SRC_FAST);

  ies_arbiter u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .nmi       (nmi),
    .firq      (firq),
    .irq       (irq),
    .mask_f    (cc_in[CC_F]),
    .mask_i    (cc_in[CC_I]),
    .sample    (sample),
    .clear_nmi (accept && pick == SRC_NMI),
    .pick      (pick),
    .nmi_pend  (nmi_pending)
  );

  ies_frame #(.SW(SW)) u_frame (
    .pc       (pc_r),
    .u        (u_r),
    .y        (y_r),
    .x        (x_r),
    .dp       (dp_r),
    .b        (b_r),
    .a        (a_r),
    .ccp      (ccp_r),
    .full     (full_r),
    .step     (step),
    .byte_out (frame_byte)
  );

  // CC image that is pushed, and CC after the mask update
  always_comb begin
    ccp_next = cc_in;
    ccp_next[CC_E] = (pick != SRC_FAST);
    ccn_base = stacked ? cc_in : ccp_next;
    ccn_next = ccn_base;
    ccn_next[CC_I] = 1'b1;
    if (pick != SRC_NORM) ccn_next[CC_F] = 1'b1;
  end

  assign push_last = full_r ? SW'(FULL_PUSH - 1) : SW'(FAST_PUSH - 1);
  assign nbytes    = full_r ? SW'(FULL_BYTES) : SW'(FAST_BYTES);
  assign sp_dec    = stk_r ? sp_r : (sp_r - AW'(nbytes));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      step     <= '0;
      src_r    <= SRC_NONE;
      stk_r    <= 1'b0;
      pc_r     <= '0;
      u_r      <= '0;
      y_r      <= '0;
      x_r      <= '0;
      sp_r     <= '0;
      vec_r    <= '0;
      dp_r     <= '0;
      b_r      <= '0;
      a_r      <= '0;
      ccp_r    <= '0;
      ccn_r    <= '0;
      hi_r     <= '0;
      done     <= 1'b0;
      wait_clr <= 1'b0;
      pc_out   <= '0;
      cc_out   <= '0;
      sp_out   <= '0;
    end else begin
      done     <= 1'b0;
      wait_clr <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            src_r <= pick;
            stk_r <= stacked;
            pc_r  <= pc_in;
            u_r   <= u_in;
            y_r   <= y_in;
            x_r   <= x_in;
            sp_r  <= sp_in;
            dp_r  <= dp_in;
            b_r   <= b_in;
            a_r   <= a_in;
            ccp_r <= ccp_next;
            ccn_r <= ccn_next;
            vec_r <= vec_of(pick);
            step  <= '0;
            state <= stacked ? ST_VEC : ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (step == push_last) begin
            step  <= '0;
            state <= ST_VEC;
          end else begin
            step <= step + SW'(1);
          end
        end
        ST_VEC: begin
          if (step == '0) begin
            hi_r <= mem_rdata;
            step <= SW'(1);
          end else begin
            pc_out   <= {hi_r, mem_rdata};
            cc_out   <= ccn_r;
            sp_out   <= sp_dec;
            done     <= 1'b1;
            wait_clr <= 1'b1;
            step     <= '0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy       = (state != ST_IDLE);
    mem_we     = (state == ST_PUSH) && (step < nbytes);
    mem_re     = (state == ST_VEC);
    bus_status = (state == ST_VEC);
    mem_wdata  = mem_we ? frame_byte : '0;
    case (state)
      ST_PUSH: mem_addr = sp_r - AW'(step) - AW'(1);
      ST_VEC:  mem_addr = vec_r + AW'(step);
      default: mem_addr = '0;
    endcase
  end
endmodule

// File: rtl/ies_checker.sv
module ies_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mem_we,
  input logic       mem_re,
  input logic       bus_status,
  input logic       done,
  input logic [7:0] cc_out
);
  AST_BS_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    bus_status |-> (mem_re && !mem_we)); // R8
  AST_NO_WRITE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re)); // R3
  AST_DONE_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_status)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re && !bus_status)); // R10
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cc_out[4]); // R6
endmodule

bind irq_entry_seq ies_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .bus_status (bus_status),
  .done       (done),
  .cc_out     (cc_out)
);

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boundary = 0, nmi = 0, firq = 0, irq = 0, stacked = 0;
  logic [7:0]  cc_in = 0, dp_in = 0, b_in = 0, a_in = 0;
  logic [15:0] sp_in = 0, pc_in = 0, u_in = 0, y_in = 0, x_in = 0;
  logic busy, mem_we, mem_re, bus_status, done, wait_clr, nmi_pending;
  logic [15:0] mem_addr, pc_out, sp_out;
  logic [7:0]  mem_wdata, mem_rdata, cc_out;

  int n_chk = 0, n_fail = 0;
  bit exp_pend = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] vbyte(input logic [15:0] a);
    return (a[7:0] * 8'd7) ^ 8'h3C;
  endfunction

  assign mem_rdata = vbyte(mem_addr);

  irq_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .nmi(nmi), .firq(firq), .irq(irq),
    .cc_in(cc_in), .stacked(stacked), .sp_in(sp_in), .pc_in(pc_in), .u_in(u_in),
    .y_in(y_in), .x_in(x_in), .dp_in(dp_in), .b_in(b_in), .a_in(a_in),
    .busy(busy), .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .bus_status(bus_status),
    .done(done), .pc_out(pc_out), .cc_out(cc_out), .sp_out(sp_out),
    .wait_clr(wait_clr), .nmi_pending(nmi_pending)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 none, 1 nmi, 2 fast, 3 normal
  function automatic int exp_src(input bit pend, input bit f, input bit i, input logic [7:0] cc);
    if (pend) return 1;
    if (f && !cc[6]) return 2;
    if (i && !cc[4]) return 3;
    return 0;
  endfunction

  function automatic logic [15:0] exp_vec(input int s);
    return (s == 1) ? 16'hFFFC : (s == 2) ? 16'hFFF6 : 16'hFFF8;
  endfunction

  function automatic logic [7:0] exp_byte(input int s, input int k);
    logic [7:0] ccp;
    ccp = cc_in;
    ccp[7] = (s != 2);
    if (s == 2 && k == 2) return ccp;
    case (k)
      0: return pc_in[7:0];  1: return pc_in[15:8];
      2: return u_in[7:0];   3: return u_in[15:8];
      4: return y_in[7:0];   5: return y_in[15:8];
      6: return x_in[7:0];   7: return x_in[15:8];
      8: return dp_in;       9: return b_in;
      10: return a_in;       default: return ccp;
    endcase
  endfunction

  task automatic randomize_regs();
    sp_in = 16'h4000 + 16'($urandom_range(0, 16'h3FFF));
    pc_in = 16'($urandom); u_in = 16'($urandom);
    y_in = 16'($urandom);  x_in = 16'($urandom);
    dp_in = 8'($urandom);  b_in = 8'($urandom); a_in = 8'($urandom);
  endtask

  task automatic entry(input bit f, input bit i, input bit stk, input bit edge_nmi, input bit mid_boundary);
    int s, cycles, nw, nbs, n_exp, nb;
    logic [7:0] cce;
    if (edge_nmi) begin
      @(negedge clk); nmi = 1;
      @(negedge clk); nmi = 0;
      exp_pend = 1;
    end
    @(negedge clk);
    firq = f; irq = i; stacked = stk; boundary = 1;
    s = exp_src(exp_pend, f, i, cc_in);
    @(negedge clk);
    boundary = 0;
    cycles = 0; nw = 0; nbs = 0;
    nb = (s == 2) ? 3 : 12;
    n_exp = stk ? 2 : ((s == 2) ? 10 : 19);
    while (busy && cycles < 40) begin
      if (mem_we) begin
        check(!stk && cycles == nw, "R5 write timing", cycles, nw);
        check(mem_addr == sp_in - 16'(nw + 1), (s == 2) ? "R4 addr" : "R3 addr", mem_addr, sp_in - 16'(nw + 1));
        check(mem_wdata == exp_byte(s, nw), (s == 2) ? "R4 data" : "R3 data", mem_wdata, exp_byte(s, nw));
        nw++;
      end
      if (bus_status) begin
        nbs++;
        check(cycles >= n_exp - 2, "R8 bs phase", cycles, n_exp - 2);
        check(mem_addr == exp_vec(s) + 16'(nbs - 1), "R2 vec addr", mem_addr, exp_vec(s) + 16'(nbs - 1));
      end
      if (mid_boundary && cycles == 3) boundary = 1;
      if (mid_boundary && cycles == 4) boundary = 0;
      cycles++;
      @(negedge clk);
    end
    if (s == 0) begin
      check(cycles == 0 && !done, "R10 no entry", cycles, 0);
    end else begin
      check(cycles == n_exp, "R7 busy cycles", cycles, n_exp);
      check(nw == (stk ? 0 : nb), stk ? "R5 no writes" : "R3 write count", nw, stk ? 0 : nb);
      check(nbs == 2 && !bus_status, "R8 bs cycles", nbs, 2);
      check(done && wait_clr, "R9 done pulse", {done, wait_clr}, 2'b11);
      check(pc_out == {vbyte(exp_vec(s)), vbyte(exp_vec(s) + 16'd1)}, "R1 R2 vector pc", pc_out,
            {vbyte(exp_vec(s)), vbyte(exp_vec(s) + 16'd1)});
      cce = cc_in;
      if (!stk) cce[7] = (s != 2);
      cce[4] = 1'b1;
      if (s != 3) cce[6] = 1'b1;
      check(cc_out == cce, "R6 cc_out", cc_out, cce);
      check(sp_out == (stk ? sp_in : sp_in - 16'(nb)), stk ? "R5 sp" : "R11 sp", sp_out,
            stk ? sp_in : sp_in - 16'(nb));
      if (s == 1) exp_pend = 0;
      @(negedge clk);
      check(!done, "R9 single pulse", done, 0);
    end
    check(nmi_pending == exp_pend, "R9 nmi pending", nmi_pending, exp_pend);
    firq = 0; irq = 0; stacked = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !bus_status && !done && !nmi_pending && !mem_we, "R10 reset state", busy, 0);

    // R1: all three eligible, non-maskable wins
    randomize_regs(); cc_in = 8'h00; entry(1, 1, 0, 1, 0);
    // R1: fast over normal
    randomize_regs(); cc_in = 8'h00; entry(1, 1, 0, 0, 0);
    // R1: fast masked falls to normal
    randomize_regs(); cc_in = 8'h40; entry(1, 1, 0, 0, 0);
    // R10: all masked
    randomize_regs(); cc_in = 8'h50; entry(1, 1, 0, 0, 0);
    // R5: stacked normal and stacked fast
    randomize_regs(); cc_in = 8'h80; entry(0, 1, 1, 0, 0);
    randomize_regs(); cc_in = 8'h0F; entry(1, 0, 1, 0, 0);
    // R10: boundary during an entry is ignored
    randomize_regs(); cc_in = 8'h00; entry(0, 1, 0, 0, 1);
    // R10: held non-maskable input triggers once
    @(negedge clk); nmi = 1; @(negedge clk); exp_pend = 1;
    randomize_regs(); cc_in = 8'h50; entry(0, 0, 0, 0, 0);
    randomize_regs(); entry(0, 0, 0, 0, 0);
    nmi = 0;

    for (int k = 0; k < 60; k++) begin
      randomize_regs();
      cc_in = 8'($urandom);
      entry(1'($urandom), 1'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule